// File: doc/BRIEF.md
# Predicated Instruction Sequencer

This block is the control sequencer of a small 16-bit register machine. Every instruction carries a 3-bit condition code, and it is one or two words long. The sequencer looks at each instruction word when it is fetched and at the zero, carry and sign flags from the datapath. From these it chooses the path of control steps: opcode fetch, operand fetch, address formation, memory read, memory write, execute and interrupt entry. It raises one strobe per step for the datapath. It also keeps a copy of the current instruction word, which the datapath decodes further.

The path is cut to suit the instruction. A one-word ALU operation needs only an opcode fetch and an execute step. An operand word adds a fetch step. A register source other than r0 adds an address step. Loads read memory before they execute, and stores write memory and never execute. An instruction whose condition fails still spends its fetch cycles and then does nothing. When allowed, the opcode fetch of the next instruction shares the execute cycle of the current one. The share is dropped when the instruction writes r15 (the program counter) or when an interrupt is taken. Interrupt entry is one cycle. In that cycle the datapath saves the PC and loads the vector, and further interrupts are masked until reset.

Top module: `pred_seq_ctrl`

## Requirements
- R1: In the cycle after reset is released, the step code is 0 (opcode fetch). The operand-fetch, address, read, write, execute and interrupt strobes are low, and the interrupt mask is clear.
- R2: A one-word instruction word has bit 12 low, bits 15:13 the condition, bits 11:8 the opcode, bits 7:4 the destination and bits 3:0 the source. A one-word ALU opcode (any opcode except 4 load and 5 store) whose condition passes takes step 0, then step 3 (execute).
- R3: An instruction with bit 12 set has an operand word. If its source field is 0 it takes steps 0, 1, 3. Otherwise it takes steps 0, 1, 2 (address), 3.
- R4: A load (opcode 4) goes through address, then read (code 4), then execute. A store (opcode 5) goes through address, then write (code 5), then back to step 0, with no execute. Both follow any operand fetch.
- R5: The read and write steps hold while the memory-ready input is low, and advance in the first cycle it is high.
- R6: The condition codes are: 000 always, 001 always (the code is an opcode-extension bit), 010 zero set, 011 zero clear, 100 carry set, 101 carry clear, 110 sign set, 111 sign clear. The flags are read in the cycle the last word of the instruction is fetched, so the datapath must supply flag values that already include any update made in that same cycle.
- R7: An instruction whose condition fails takes only its fetch steps (0, plus 1 if it has an operand word). It then returns to step 0 without any address, read, write or execute strobe.
- R8: During execute, the opcode fetch of the next instruction is asserted and that word is decoded in the same cycle. This does not happen when the instruction writes r15, or when an interrupt is taken. An instruction writes r15 when its destination is 15 and its opcode is neither 3 (compare) nor 5 (store).
- R9: A short branch is an ALU instruction (for example opcode 6 increment or 7 decrement) with destination r15. When its condition passes it costs step 0 plus execute, and the next instruction starts with a fresh step 0. When its condition fails it costs step 0 only.
- R10: A pending, unmasked interrupt at the end of an instruction sends the sequencer to step 6 (interrupt entry) for one cycle with the interrupt strobe high. The mask is then set, and after that a pending interrupt is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction or operand word from the fetch path |
| flag_z_i | input | 1 | Zero flag, forwarded |
| flag_c_i | input | 1 | Carry flag, forwarded |
| flag_n_i | input | 1 | Sign flag, forwarded |
| irq_i | input | 1 | Interrupt request level |
| mem_ready_i | input | 1 | Data memory has completed the access |
| state_o | output | 3 | Current step: 0 fetch, 1 operand, 2 address, 3 execute, 4 read, 5 write, 6 interrupt |
| ifetch_o | output | 1 | Opcode word is taken this cycle |
| opfetch_o | output | 1 | Operand word is taken this cycle |
| ead_o | output | 1 | Form the effective address |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| exec_o | output | 1 | Execute and write back the current instruction |
| int_o | output | 1 | Save PC and load the interrupt vector |
| int_mask_o | output | 1 | Interrupts are masked |
| ir_o | output | 16 | Current instruction word |

## Verification
Two things can happen in the same cycle. The execute step of one instruction can coincide with the opcode fetch of the next, and in that cycle an interrupt request or a write to r15 has to cancel the shared fetch. The bench places a one-word ALU operation with a two-word operation behind it and checks that the second one moves straight from the shared cycle into its operand fetch. It then repeats the ALU operation with the interrupt raised and checks that the fetch strobe falls in execute, that the next step is interrupt entry, and that after masking the same stimulus overlaps again. Branches to r15 and a compare aimed at r15 are checked step by step in the same way.

// File: rtl/pred_seq_pkg.sv
`timescale 1ns/1ps
package pred_seq_pkg;

    localparam int WORD_W = 16;
    localparam int PRED_W = 3;
    localparam int OPC_W  = 4;
    localparam int RIDX_W = 4;

    localparam logic [RIDX_W-1:0] PC_IDX   = '1;
    localparam logic [OPC_W-1:0]  OP_CMP   = OPC_W'(3);
    localparam logic [OPC_W-1:0]  OP_LOAD  = OPC_W'(4);
    localparam logic [OPC_W-1:0]  OP_STORE = OPC_W'(5);

    typedef enum logic [2:0] {
        ST_FETCH0 = 3'd0,
        ST_FETCH1 = 3'd1,
        ST_EAD    = 3'd2,
        ST_EXEC   = 3'd3,
        ST_RDMEM  = 3'd4,
        ST_WRMEM  = 3'd5,
        ST_INT    = 3'd6
    } seq_state_e;

    typedef enum logic [PRED_W-1:0] {
        PR_ALWAYS = 3'b000,
        PR_EXT    = 3'b001,
        PR_ZS     = 3'b010,
        PR_ZC     = 3'b011,
        PR_CS     = 3'b100,
        PR_CC     = 3'b101,
        PR_NS     = 3'b110,
        PR_NC     = 3'b111
    } pred_e;

    // Raw layout of an opcode word
    typedef struct packed {
        pred_e               pred;
        logic                has_opnd;
        logic [OPC_W-1:0]    opc;
        logic [RIDX_W-1:0]   dst;
        logic [RIDX_W-1:0]   src;
    } iword_t;

    // What the sequencer needs from an opcode word
    typedef struct packed {
        pred_e pred;
        logic  has_opnd;
        logic  is_load;
        logic  is_store;
        logic  src_r0;
        logic  wr_pc;
    } idec_t;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
    } flags_t;

endpackage

// File: rtl/pred_seq_decode.sv
`timescale 1ns/1ps
module pred_seq_decode
    import pred_seq_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output idec_t             dec_o
);

    iword_t w;
    assign w = iword_t'(word_i);

    always_comb begin
        dec_o.pred     = w.pred;
        dec_o.has_opnd = w.has_opnd;
        dec_o.is_load  = (w.opc == OP_LOAD);
        dec_o.is_store = (w.opc == OP_STORE);
        dec_o.src_r0   = (w.src == '0);
        // compare and store leave the register file untouched
        dec_o.wr_pc    = (w.dst == PC_IDX) && (w.opc != OP_CMP) && (w.opc != OP_STORE);
    end

endmodule

// File: rtl/pred_seq_cond.sv
`timescale 1ns/1ps
module pred_seq_cond
    import pred_seq_pkg::*;
(
    input  pred_e  pred_i,
    input  flags_t flags_i,
    output logic   pass_o
);

    always_comb begin
        unique case (pred_i)
            PR_ALWAYS, PR_EXT: pass_o = 1'b1;
            PR_ZS:             pass_o = flags_i.z;
            PR_ZC:             pass_o = !flags_i.z;
            PR_CS:             pass_o = flags_i.c;
            PR_CC:             pass_o = !flags_i.c;
            PR_NS:             pass_o = flags_i.n;
            PR_NC:             pass_o = !flags_i.n;
            default:           pass_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/pred_seq_irq.sv
`timescale 1ns/1ps
module pred_seq_irq (
    input  logic clk,
    input  logic rst,
    input  logic irq_i,
    input  logic enter_i,
    output logic take_o,
    output logic mask_o
);

    logic mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= 1'b0;
        else if (enter_i)
            mask_q <= 1'b1;
    end

    assign take_o = irq_i && !mask_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/pred_seq_ctrl.sv
`timescale 1ns/1ps
module pred_seq_ctrl
    import pred_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       instr_i,
    input  logic              flag_z_i,
    input  logic              flag_c_i,
    input  logic              flag_n_i,
    input  logic              irq_i,
    input  logic              mem_ready_i,
    output logic [2:0]        state_o,
    output logic              ifetch_o,
    output logic              opfetch_o,
    output logic              ead_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              exec_o,
    output logic              int_o,
    output logic              int_mask_o,
    output logic [15:0]       ir_o
);

    seq_state_e          st_q, st_d;
    logic [WORD_W-1:0]   ir_q;
    logic [WORD_W-1:0]   dec_word;
    idec_t               dec;
    flags_t              flg;
    logic                pred_pass;
    logic                irq_take;
    logic                fetch_now;
    logic                overlap_ok;
    logic                cur_load_q, cur_store_q, cur_wr_pc_q;
    seq_state_e          done_st, after_last, after_f0;

    // The decoder sees the live word in fetch slots, the held word otherwise
    assign dec_word = (st_q == ST_FETCH0 || st_q == ST_EXEC) ? instr_i : ir_q;

    pred_seq_decode u_dec (
        .word_i (dec_word),
        .dec_o  (dec)
    );

    assign flg = '{z: flag_z_i, c: flag_c_i, n: flag_n_i};

    pred_seq_cond u_cond (
        .pred_i  (dec.pred),
        .flags_i (flg),
        .pass_o  (pred_pass)
    );

    pred_seq_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .irq_i   (irq_i),
        .enter_i (st_q == ST_INT),
        .take_o  (irq_take),
        .mask_o  (int_mask_o)
    );

    assign overlap_ok = !cur_wr_pc_q && !irq_take;
    assign fetch_now  = (st_q == ST_FETCH0) || (st_q == ST_EXEC && overlap_ok);
    assign done_st    = irq_take ? ST_INT : ST_FETCH0;

    // Path after the last fetch word of the decoded instruction
    always_comb begin
        if (!pred_pass)
            after_last = done_st;
        else if (dec.is_load || dec.is_store || (dec.has_opnd && !dec.src_r0))
            after_last = ST_EAD;
        else
            after_last = ST_EXEC;
    end

    assign after_f0 = dec.has_opnd ? ST_FETCH1 : after_last;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FETCH0: st_d = after_f0;
            ST_FETCH1: st_d = after_last;
            ST_EAD: begin
                if (cur_load_q)
                    st_d = ST_RDMEM;
                else if (cur_store_q)
                    st_d = ST_WRMEM;
                else
                    st_d = ST_EXEC;
            end
            ST_RDMEM:  st_d = mem_ready_i ? ST_EXEC : ST_RDMEM;
            ST_WRMEM:  st_d = mem_ready_i ? done_st : ST_WRMEM;
            ST_EXEC:   st_d = overlap_ok ? after_f0 : done_st;
            ST_INT:    st_d = ST_FETCH0;
            default:   st_d = ST_FETCH0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_FETCH0;
            ir_q        <= '0;
            cur_load_q  <= 1'b0;
            cur_store_q <= 1'b0;
            cur_wr_pc_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (fetch_now) begin
                ir_q        <= instr_i;
                cur_load_q  <= dec.is_load;
                cur_store_q <= dec.is_store;
                cur_wr_pc_q <= dec.wr_pc;
            end
        end
    end

    assign state_o   = st_q;
    assign ifetch_o  = fetch_now;
    assign opfetch_o = (st_q == ST_FETCH1);
    assign ead_o     = (st_q == ST_EAD);
    assign mem_rd_o  = (st_q == ST_RDMEM);
    assign mem_wr_o  = (st_q == ST_WRMEM);
    assign exec_o    = (st_q == ST_EXEC);
    assign int_o     = (st_q == ST_INT);
    assign ir_o      = ir_q;

endmodule

// File: rtl/pred_seq_chk.sv
`timescale 1ns/1ps
module pred_seq_chk
    import pred_seq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        mem_ready_i,
    input logic [2:0]  state_o,
    input logic        ifetch_o,
    input logic        opfetch_o,
    input logic        ead_o,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic        exec_o,
    input logic        int_o,
    input logic        int_mask_o,
    input logic [15:0] ir_o
);

    logic ir_hits_pc;
    assign ir_hits_pc = (ir_o[7:4] == 4'hF) && (ir_o[11:8] != 4'h3) && (ir_o[11:8] != 4'h5);

    a_r5_read_holds: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_RDMEM && !mem_ready_i) |=> state_o == ST_RDMEM);

    a_r5_write_holds: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_WRMEM && !mem_ready_i) |=> state_o == ST_WRMEM);

    a_r4_read_then_exec: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_RDMEM && mem_ready_i) |=> state_o == ST_EXEC);

    a_r4_store_skips_exec: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_WRMEM && mem_ready_i) |=> state_o != ST_EXEC);

    a_r3_addr_exit: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_EAD |=> (state_o == ST_EXEC || state_o == ST_RDMEM || state_o == ST_WRMEM));

    a_r8_no_overlap_on_pc: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_EXEC && ir_hits_pc) |-> !ifetch_o);

    a_r10_entry_masks: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_INT |=> (int_mask_o && state_o == ST_FETCH0));

    a_r10_masked_no_entry: assert property (@(posedge clk) disable iff (rst)
        int_mask_o |-> !int_o);

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({opfetch_o, ead_o, mem_rd_o, mem_wr_o, exec_o, int_o}));

endmodule

bind pred_seq_ctrl pred_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_ready_i (mem_ready_i),
    .state_o     (state_o),
    .ifetch_o    (ifetch_o),
    .opfetch_o   (opfetch_o),
    .ead_o       (ead_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .exec_o      (exec_o),
    .int_o       (int_o),
    .int_mask_o  (int_mask_o),
    .ir_o        (ir_o)
);

// File: tb/pred_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pred_seq_ctrl_tb;

    localparam logic [2:0] F0 = 3'd0, F1 = 3'd1, EA = 3'd2, EX = 3'd3,
                           RD = 3'd4, WR = 3'd5, IN = 3'd6;
    localparam logic [15:0] FILL = 16'h0112;
    localparam int NV = 22;

    // {req(4), word(16), zcn(3), last index(3), steps s0..s5 (18), writes(2)}
    localparam logic [45:0] VEC [NV] = '{
        {4'd2,  16'h0112, 3'b000, 3'd1, {F0,EX,F0,F0,F0,F0}, 2'd1}, // R2 plain ALU
        {4'd6,  16'h4112, 3'b100, 3'd1, {F0,EX,F0,F0,F0,F0}, 2'd1}, // R6 Z pass
        {4'd7,  16'h4112, 3'b000, 3'd1, {F0,F0,F0,F0,F0,F0}, 2'd0}, // R7 Z fail
        {4'd6,  16'h6112, 3'b000, 3'd1, {F0,EX,F0,F0,F0,F0}, 2'd1}, // R6 NZ pass
        {4'd7,  16'h8112, 3'b000, 3'd1, {F0,F0,F0,F0,F0,F0}, 2'd0}, // R7 C fail
        {4'd6,  16'hA112, 3'b000, 3'd1, {F0,EX,F0,F0,F0,F0}, 2'd1}, // R6 NC pass
        {4'd6,  16'hC112, 3'b001, 3'd1, {F0,EX,F0,F0,F0,F0}, 2'd1}, // R6 MI pass
        {4'd7,  16'hE112, 3'b001, 3'd1, {F0,F0,F0,F0,F0,F0}, 2'd0}, // R7 PL fail
        {4'd6,  16'h2112, 3'b000, 3'd1, {F0,EX,F0,F0,F0,F0}, 2'd1}, // R6 ext code
        {4'd3,  16'h1110, 3'b000, 3'd2, {F0,F1,EX,F0,F0,F0}, 2'd1}, // R3 r0 source
        {4'd3,  16'h1112, 3'b000, 3'd3, {F0,F1,EA,EX,F0,F0}, 2'd1}, // R3 reg source
        {4'd7,  16'h5112, 3'b000, 3'd2, {F0,F1,F0,F0,F0,F0}, 2'd0}, // R7 two-word fail
        {4'd4,  16'h0412, 3'b000, 3'd3, {F0,EA,RD,EX,F0,F0}, 2'd1}, // R4 load
        {4'd7,  16'h6412, 3'b100, 3'd1, {F0,F0,F0,F0,F0,F0}, 2'd0}, // R7 load fail
        {4'd4,  16'h0512, 3'b000, 3'd3, {F0,EA,WR,F0,F0,F0}, 2'd1}, // R4 store
        {4'd4,  16'h1510, 3'b000, 3'd4, {F0,F1,EA,WR,F0,F0}, 2'd1}, // R4 two-word store
        {4'd7,  16'h9510, 3'b000, 3'd2, {F0,F1,F0,F0,F0,F0}, 2'd0}, // R7 store fail
        {4'd9,  16'h06F3, 3'b000, 3'd2, {F0,EX,F0,F0,F0,F0}, 2'd1}, // R9 inc pc
        {4'd9,  16'h67F3, 3'b000, 3'd2, {F0,EX,F0,F0,F0,F0}, 2'd1}, // R9 NZ dec pc
        {4'd9,  16'h47F3, 3'b000, 3'd1, {F0,F0,F0,F0,F0,F0}, 2'd0}, // R9 branch fails
        {4'd8,  16'h03F1, 3'b000, 3'd1, {F0,EX,F0,F0,F0,F0}, 2'd1}, // R8 compare to r15
        {4'd8,  16'h04F2, 3'b000, 3'd4, {F0,EA,RD,EX,F0,F0}, 2'd1}  // R8 load to r15
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr_i = FILL;
    logic        flag_z_i = 1'b0, flag_c_i = 1'b0, flag_n_i = 1'b0;
    logic        irq_i = 1'b0;
    logic        mem_ready_i = 1'b1;
    logic [2:0]  state_o;
    logic        ifetch_o, opfetch_o, ead_o, mem_rd_o, mem_wr_o, exec_o, int_o, int_mask_o;
    logic [15:0] ir_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pred_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .instr_i(instr_i),
        .flag_z_i(flag_z_i), .flag_c_i(flag_c_i), .flag_n_i(flag_n_i),
        .irq_i(irq_i), .mem_ready_i(mem_ready_i),
        .state_o(state_o), .ifetch_o(ifetch_o), .opfetch_o(opfetch_o),
        .ead_o(ead_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .exec_o(exec_o), .int_o(int_o), .int_mask_o(int_mask_o), .ir_o(ir_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; instr_i = FILL; irq_i = 1'b0; mem_ready_i = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive this cycle's word, settle, then compare step and fetch strobe
    task automatic cyc(input string tag, input logic [15:0] w, input int st, input int fetch);
        instr_i = w;
        #1;
        chk(tag, int'(state_o), st);
        if (fetch >= 0) chk(tag, int'(ifetch_o), fetch);
    endtask

    initial begin
        #500000;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        flag_z_i = 0; flag_c_i = 0; flag_n_i = 0;
        do_reset();
        #1;
        chk("R1 step", int'(state_o), 0);
        chk("R1 strobes", int'({opfetch_o, ead_o, mem_rd_o, mem_wr_o, exec_o, int_o}), 0);
        chk("R1 mask", int'(int_mask_o), 0);
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [45:0] e;
            int len, wr;
            string tag;
            e = VEC[v];
            len = int'(e[22:20]);
            tag = $sformatf("R%0d vec%0d", int'(e[45:42]), v);
            {flag_z_i, flag_c_i, flag_n_i} = e[25:23];
            do_reset();
            wr = 0;
            for (int i = 0; i <= len; i++) begin
                cyc(tag, (i == 0) ? e[41:26] : FILL, int'(e[19 - 3*i -: 3]),
                    (i == 0 || i == len) ? 1 : 0);
                wr += int'(exec_o) + int'(mem_wr_o) + int'(ead_o && !e[1:0]) + int'(mem_rd_o && !e[1:0]);
                @(negedge clk);
            end
            chk({tag, " writes"}, wr, int'(e[1:0]));
        end

        // R5 read waits for ready
        {flag_z_i, flag_c_i, flag_n_i} = 3'b000;
        do_reset();
        cyc("R5 rd", 16'h0412, 0, 1); @(negedge clk);
        cyc("R5 rd", FILL, 2, 0); mem_ready_i = 1'b0; @(negedge clk);
        cyc("R5 rd", FILL, 4, 0); @(negedge clk);
        cyc("R5 rd", FILL, 4, 0); @(negedge clk);
        cyc("R5 rd", FILL, 4, 0); mem_ready_i = 1'b1; @(negedge clk);
        cyc("R5 rd", FILL, 3, 1); @(negedge clk);

        // R5 write waits for ready
        do_reset();
        cyc("R5 wr", 16'h0512, 0, 1); @(negedge clk);
        cyc("R5 wr", FILL, 2, 0); mem_ready_i = 1'b0; @(negedge clk);
        cyc("R5 wr", FILL, 5, 0); @(negedge clk);
        cyc("R5 wr", FILL, 5, 0); mem_ready_i = 1'b1; @(negedge clk);
        cyc("R5 wr", FILL, 0, 1); @(negedge clk);

        // R8 overlapped fetch feeds a two-word instruction
        do_reset();
        cyc("R8 chain", FILL, 0, 1); @(negedge clk);
        cyc("R8 chain", 16'h1110, 3, 1); @(negedge clk);
        cyc("R8 chain", FILL, 1, 0); @(negedge clk);
        cyc("R8 chain", FILL, 3, 1); @(negedge clk);

        // R10 interrupt cancels overlap, then is masked
        do_reset();
        irq_i = 1'b1;
        cyc("R10 irq", FILL, 0, 1); @(negedge clk);
        cyc("R10 irq", FILL, 3, 0); @(negedge clk);
        cyc("R10 irq", FILL, 6, 0);
        chk("R10 int strobe", int'(int_o), 1);
        @(negedge clk);
        cyc("R10 irq", FILL, 0, 1);
        chk("R10 mask set", int'(int_mask_o), 1);
        @(negedge clk);
        cyc("R10 masked", FILL, 3, 1);
        chk("R10 masked no entry", int'(int_o), 0);
        @(negedge clk);

        // R10 interrupt after a skipped instruction (R7)
        do_reset();
        irq_i = 1'b1;
        {flag_z_i, flag_c_i, flag_n_i} = 3'b000;
        cyc("R10 skip irq", 16'h4112, 0, 1); @(negedge clk);
        cyc("R10 skip irq", FILL, 6, 0); @(negedge clk);
        cyc("R10 skip irq", FILL, 0, 1);
        irq_i = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule